// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single pulse-width-modulation channel driven by a down counter. Software-visible buffer values for the period and the compare threshold feed the block, but the counter works only from its own working copies. The working copies are refreshed in two cases. One is an explicit update command. The other is the counter running out while automatic reload is selected. Because of this, buffer values may be rewritten at any moment without disturbing the period in progress.

The counter advances on the cycles where an external tick enable from a clock-divider stage is high. The channel compares its working count against its working threshold to form the waveform, can invert the polarity, and emits a one-clock expiry pulse each time the count runs out. A controller with three states sequences the channel:
- `ST_IDLE`: stopped, count held.
- `ST_RUN`: counting.
- `ST_DONE`: stopped after a final period without reload.

The controller has these transitions:
- IDLE→RUN when start is high.
- RUN→IDLE when start drops.
- RUN→DONE on expiry with reload clear.
- DONE→IDLE when start drops.
- Any state→RUN or IDLE, following start, while an update command is applied.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset, the working count and working threshold are 0, the controller is stopped, `expire` is 0 and `pwm_out` equals `invert`.
- R2: On every clock where `man_upd` is high, the working count takes `cnt_buf` and the working threshold takes `cmp_buf`. The counter does not step on such a clock. The controller goes to RUN if `start` is high and to IDLE otherwise.
- R3: While running, the count decreases by exactly one on each clock where both `start` and `tick_en` are high. On all other clocks it holds its value.
- R4: With `auto_rld` high, a tick that finds the count at 0 reloads both working values from the buffers, so a count buffer of N gives a period of N+1 ticks.
- R5: With `auto_rld` low, a tick that finds the count at 0 stops the channel (DONE). The channel stays stopped until `start` is dropped and raised again, or an update command is given.
- R6: While running, the un-inverted waveform is 0 when the working count is greater than the working threshold, and 1 when it is less than or equal to it.
- R7: A working threshold of all ones gives an output that is active on every clock the channel runs (100% duty).
- R8: `pwm_out` is the un-inverted waveform XOR `invert` while running. When stopped (IDLE or DONE) it equals `invert`.
- R9: `expire` is high for one clock, on the clock after each tick that finds the count at 0, in both reload modes.
- R10: Writing `cnt_buf` or `cmp_buf` without an update command or an auto-reload expiry leaves the waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer tick enable from the divider |
| start | input | 1 | Run control |
| man_upd | input | 1 | Copy buffers into working registers while high |
| auto_rld | input | 1 | Reload from buffers on expiry |
| invert | input | 1 | Output polarity flip |
| cnt_buf | input | CNT_W | Period buffer (period = value + 1 ticks) |
| cmp_buf | input | CNT_W | Threshold buffer; all ones means full duty |
| pwm_out | output | 1 | PWM waveform |
| expire | output | 1 | One-clock pulse per count expiry |

## Verification
The hardest situation to reach from the ports is the last case of the data path. In that case a buffer rewritten mid-period takes effect only at the expiry reload, and the expiry coincides with a sparse or irregular tick enable. A working count of zero also has to meet a reload-disabled stop. The stimulus gets there in two steps. First it rewrites the buffers several ticks before an expiry while gating the tick enable in an uneven pattern. Then it clears reload in the middle of a period and later restarts the stopped channel. A behavioural model follows each case and is compared on every clock.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } chan_state_e;
endpackage

// File: rtl/pwm_dbuf_ctrl.sv
module pwm_dbuf_ctrl
    import pwm_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic man_upd,
    input  logic tick_en,
    input  logic auto_rld,
    input  logic cnt_zero,
    output logic load_o,
    output logic dec_o,
    output logic hit_o,
    output logic running_o
);
    chan_state_e state_q, state_d;
    logic        step;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign step = (state_q == ST_RUN) && start && tick_en && !man_upd;

    // next state
    always_comb begin
        state_d = state_q;
        if (man_upd) begin
            state_d = start ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_d = ST_RUN;
                ST_RUN: begin
                    if (!start)
                        state_d = ST_IDLE;
                    else if (step && cnt_zero && !auto_rld)
                        state_d = ST_DONE;
                end
                ST_DONE: if (!start) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        hit_o     = step && cnt_zero;
        dec_o     = step && !cnt_zero;
        load_o    = man_upd || (step && cnt_zero && auto_rld);
        running_o = (state_q == ST_RUN);
    end

    AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) != ST_DONE)
            |-> ($past(state_q) == ST_RUN && !$past(auto_rld))) else $error("done entry"); // R5
    AST_UPD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        man_upd |-> !dec_o && !hit_o) else $error("step under update"); // R2
endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] cnt_buf_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] STEP_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (load_i) begin
            cnt_q <= cnt_buf_i;
            cmp_q <= cmp_buf_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - STEP_ONE;
        end
    end

    assign cnt_o  = cnt_q;
    assign cmp_o  = cmp_q;
    assign zero_o = (cnt_q == '0);

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) |-> (cnt_q == $past(cnt_buf_i) && cmp_q == $past(cmp_buf_i))) else $error("load"); // R2
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_i) && !$past(load_i)) |-> (cnt_q + STEP_ONE == $past(cnt_q))) else $error("dec"); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dec_i) && !$past(load_i)) |-> ($stable(cnt_q) && $stable(cmp_q))) else $error("hold"); // R3
endmodule

// File: rtl/pwm_dbuf_outgen.sv
module pwm_dbuf_outgen #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running_i,
    input  logic             invert_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             pwm_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] FULL_DUTY = {CNT_W{1'b1}};

    logic raw_level;
    logic expire_q;

    always_comb begin
        raw_level = running_i && (cnt_i <= cmp_i);
        pwm_o     = raw_level ^ invert_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) expire_q <= 1'b0;
        else        expire_q <= hit_i;
    end

    assign expire_o = expire_q;

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (running_i && cmp_i == FULL_DUTY) |-> (pwm_o != invert_i)) else $error("full duty"); // R7
    AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !running_i |-> (pwm_o == invert_i)) else $error("stop level"); // R8
    AST_EXPIRE_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |-> (cnt_i == '0)) else $error("expiry"); // R9
endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic             man_upd,
    input  logic             auto_rld,
    input  logic             invert,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic             pwm_out,
    output logic             expire
);
    logic             load_w, dec_w, hit_w, running_w, zero_w;
    logic [CNT_W-1:0] cnt_w, cmp_w;

    pwm_dbuf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .man_upd  (man_upd),
        .tick_en  (tick_en),
        .auto_rld (auto_rld),
        .cnt_zero (zero_w),
        .load_o   (load_w),
        .dec_o    (dec_w),
        .hit_o    (hit_w),
        .running_o(running_w)
    );

    pwm_dbuf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .dec_i    (dec_w),
        .cnt_buf_i(cnt_buf),
        .cmp_buf_i(cmp_buf),
        .cnt_o    (cnt_w),
        .cmp_o    (cmp_w),
        .zero_o   (zero_w)
    );

    pwm_dbuf_outgen #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .running_i(running_w),
        .invert_i (invert),
        .hit_i    (hit_w),
        .cnt_i    (cnt_w),
        .cmp_i    (cmp_w),
        .pwm_o    (pwm_out),
        .expire_o (expire)
    );

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !$past(auto_rld)) |=> !expire) else $error("pulse"); // R9
endmodule

// File: tb/test_pwm_dbuf_channel.sv
module test_pwm_dbuf_channel;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, start = 1'b0, man_upd = 1'b0, auto_rld = 1'b0, invert = 1'b0;
    logic [W-1:0] cnt_buf = '0, cmp_buf = '0;
    logic pwm_out, expire;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    longint m_cnt = 0, m_cmp = 0;
    bit m_run = 0, m_done = 0, m_exp = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    pwm_dbuf_channel #(.CNT_W(W)) i_pwm_dbuf_channel (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
        .man_upd(man_upd), .auto_rld(auto_rld), .invert(invert),
        .cnt_buf(cnt_buf), .cmp_buf(cmp_buf),
        .pwm_out(pwm_out), .expire(expire)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic model_pwm();
        if (!m_run) return invert;
        return ((m_cnt <= m_cmp) ? 1'b1 : 1'b0) ^ invert;
    endfunction

    task automatic model_step();
        bit stp, hit;
        stp = m_run && start && tick_en && !man_upd;
        hit = stp && (m_cnt == 0);
        m_exp = hit;
        if (man_upd) begin
            m_cnt = longint'(cnt_buf); m_cmp = longint'(cmp_buf);
            m_run = start; m_done = 0;
        end else if (m_run) begin
            if (!start) m_run = 0;
            else if (hit) begin
                if (auto_rld) begin m_cnt = longint'(cnt_buf); m_cmp = longint'(cmp_buf); end
                else begin m_run = 0; m_done = 1; end
            end else if (stp) m_cnt = m_cnt - 1;
        end else if (m_done) begin
            if (!start) m_done = 0;
        end else if (start) m_run = 1;
    endtask

    // one clock: inputs already set, advance model, compare after the edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        #2;
        check(tag, pwm_out, model_pwm(), "pwm_out");
        check(tag, expire, m_exp, "expire");
    endtask

    task automatic run(input int n, input int tick_every);
        for (int k = 0; k < n; k++) begin
            tick_en = (tick_every <= 1) ? 1'b1 : ((k % tick_every) == 0);
            cyc();
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        // R1 reset state
        #35;
        check("R1", pwm_out, 1'b0, "pwm_out in reset");
        check("R1", expire, 1'b0, "expire in reset");
        rst_n = 1'b1;
        tag = "R1";
        run(3, 1);

        // R2 update while stopped, then held while running with ticks
        tag = "R2";
        cnt_buf = 5; cmp_buf = 2; man_upd = 1'b1;
        run(2, 1);
        start = 1'b1; auto_rld = 1'b1;
        run(3, 1);
        man_upd = 1'b0;

        // R4 R6 continuous ticks, period N+1
        tag = "R4";
        run(24, 1);

        // R10 buffer change mid period, effective only at reload
        tag = "R10";
        cnt_buf = 3; cmp_buf = 0;
        run(14, 1);

        // R3 sparse tick enable
        tag = "R3";
        run(30, 3);
        tick_en = 1'b0;
        run(1, 0);

        // R7 full duty threshold
        tag = "R7";
        cnt_buf = 6; cmp_buf = '1; man_upd = 1'b1;
        cyc();
        man_upd = 1'b0;
        run(20, 1);

        // R8 invert while running and stopped
        tag = "R8";
        cnt_buf = 4; cmp_buf = 1; man_upd = 1'b1; cyc(); man_upd = 1'b0;
        invert = 1'b1;
        run(12, 1);
        start = 1'b0;
        run(4, 1);
        invert = 1'b0;
        run(2, 1);
        start = 1'b1;

        // R9 expiry every tick with zero period
        tag = "R9";
        cnt_buf = 0; cmp_buf = 0; man_upd = 1'b1; cyc(); man_upd = 1'b0;
        run(10, 1);
        run(12, 2);

        // R5 single shot stop and restart
        tag = "R5";
        cnt_buf = 5; cmp_buf = 3; man_upd = 1'b1; cyc(); man_upd = 1'b0;
        run(2, 1);
        auto_rld = 1'b0;
        run(14, 1);
        start = 1'b0;
        run(2, 1);
        start = 1'b1;
        run(6, 1);
        man_upd = 1'b1; cyc(); man_upd = 1'b0;
        run(10, 2);

        // R6 threshold above and below count with inversion off
        tag = "R6";
        auto_rld = 1'b1;
        cnt_buf = 9; cmp_buf = 7; man_upd = 1'b1; cyc(); man_upd = 1'b0;
        run(25, 1);

        finish_up();
    end
endmodule